// File: doc/BRIEF.md
# Ring-Phase Digital Loop Detector and Filter

This block is the phase detector and loop filter of a digital PLL whose controlled oscillator is a nine-stage ring. It runs in the sense-clock domain, and every rising edge of `clk` is one sample. On each sample it takes two inputs. The first is a 4-bit count of oscillator rising edges. The second is a 9-bit snapshot of the ring nodes. It combines them into an absolute phase whose unit is one ninth of an oscillator period, and it measures how many of those units the oscillator advanced since the previous sample.

When the loop is locked, the oscillator advances by exactly 90 units per sample. The block subtracts the measured advance from that target. A saturating integrator accumulates the difference, which turns the per-sample frequency error into a phase error. A proportional-plus-integral stage with right-shift gains then filters the phase error into a signed control word for the oscillator.

A snapshot that is not a clean rotating thermometer pattern is flagged and discarded. The phase reference is then dropped and picked up again from the next clean sample.

Top module: `ring_phase_loop`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its stored state. After that edge `ctrl_word` is 0, `ctrl_valid` is 0 and `snap_err` is 0. The first clean sample after reset only stores a phase reference and gives `ctrl_valid` = 0.
- R2: The fine index is the one bit position i (0..8) where `ring_snap[i]` is 1 and `ring_snap[(i+8) mod 9]` is 0. The absolute phase is `coarse_cnt`*9 + fine index.
- R3: The advance is (phase now − stored phase) mod 144, so a wrap of the counter still gives a positive advance. The error is 90 − advance, which lies in −53..90.
- R4: A signed 16-bit integrator adds the error on every update. It clamps at −32768 and 32767 and never wraps.
- R5: A second signed 16-bit accumulator adds the new integrator value on every update. It clamps at the same limits.
- R6: On an update, at the same clock edge, `ctrl_word` becomes (integrator >>> `kp_shift`) + (accumulator >>> `ki_shift`), using the values after the update, clamped to −2048..2047, and `ctrl_valid` is 1 for that cycle. The shifts are arithmetic.
- R7: A snapshot with zero or more than one such transition sets `snap_err` to 1 for that cycle and gives `ctrl_valid` = 0. It leaves the integrator and the accumulator unchanged. It also drops the stored phase, so the next clean sample produces no update.
- R8: `ctrl_word` holds its value in every cycle in which `ctrl_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sense clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coarse_cnt | input | 4 | Oscillator rising-edge count, wraps at 16 |
| ring_snap | input | 9 | Captured levels of the nine ring nodes |
| kp_shift | input | 4 | Right shift applied to the integrator (proportional path) |
| ki_shift | input | 4 | Right shift applied to the accumulator (integral path) |
| ctrl_word | output | 12 | Signed oscillator control word |
| ctrl_valid | output | 1 | High in a cycle where `ctrl_word` was updated |
| snap_err | output | 1 | High in a cycle whose snapshot was rejected |

## Verification
A wrong stored phase shows up at the first update after it goes wrong: the error is off, and the integrator carries that offset into `ctrl_word` in the same cycle and in every later one. A wrap or sign fault in either accumulator shows up as a sudden sign flip of `ctrl_word`. To catch it, the bench holds a constant error long enough to reach both clamps and uses large shifts that bring the clamped values into the 12-bit output range. A reference that is not dropped after a rejected snapshot shows up one cycle later as an unexpected `ctrl_valid`. The reference model compares all three outputs on every clock, so each such fault is reported within a cycle of reaching the ports.

// File: rtl/ring_phase_pkg.sv
`timescale 1ns/1ps
package ring_phase_pkg;

  typedef enum logic {REF_EMPTY = 1'b0, REF_HELD = 1'b1} ref_state_e;

  function automatic int sat_int(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/ring_snap_decode.sv
`timescale 1ns/1ps
module ring_snap_decode #(
  parameter int NPH   = 9,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPH-1:0]   snap,
  output logic [IDX_W-1:0] fine_idx,
  output logic             bad
);
  localparam int CNT_W = $clog2(NPH + 1);

  logic [CNT_W-1:0] edges;

  always_comb begin
    edges    = '0;
    fine_idx = '0;
    for (int i = 0; i < NPH; i++) begin
      if (snap[i] && !snap[(i + NPH - 1) % NPH]) begin
        edges    = edges + CNT_W'(1);
        fine_idx = IDX_W'(i);
      end
    end
    bad = (edges != CNT_W'(1));
  end

  // R2
  fine_range_chk: assert property (@(posedge clk) disable iff (rst)
    !bad |-> (int'(fine_idx) < NPH && snap[fine_idx]));

endmodule

// File: rtl/ring_phase_diff.sv
`timescale 1ns/1ps
module ring_phase_diff
  import ring_phase_pkg::*;
#(
  parameter int CW     = 4,
  parameter int NPH    = 9,
  parameter int IDX_W  = 4,
  parameter int TARGET = 90,
  parameter int PH_W   = 8,
  parameter int ERR_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CW-1:0]           coarse,
  input  logic [IDX_W-1:0]        fine,
  input  logic                    bad,
  output logic                    upd,
  output logic signed [ERR_W-1:0] err
);
  localparam int PH_MOD = (1 << CW) * NPH;

  ref_state_e      ref_st;
  logic [PH_W-1:0] ref_ph;
  int              ph_now;
  int              adv;

  always_comb begin
    ph_now = int'(coarse) * NPH + int'(fine);
    adv    = ph_now - int'(ref_ph);
    if (adv < 0) adv = adv + PH_MOD;
    err    = ERR_W'(TARGET - adv);
    upd    = !bad && (ref_st == REF_HELD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_st <= REF_EMPTY;
      ref_ph <= '0;
    end else if (bad) begin
      ref_st <= REF_EMPTY;
    end else begin
      ref_st <= REF_HELD;
      ref_ph <= PH_W'(ph_now);
    end
  end

  // R3
  adv_range_chk: assert property (@(posedge clk) disable iff (rst)
    upd |-> (int'(err) <= TARGET && int'(err) > TARGET - PH_MOD));

endmodule

// File: rtl/ring_pi_filter.sv
`timescale 1ns/1ps
module ring_pi_filter
  import ring_phase_pkg::*;
#(
  parameter int ERR_W  = 10,
  parameter int INT_W  = 16,
  parameter int OUT_W  = 12,
  parameter int SH_W   = 4,
  parameter int PH_MOD = 144,
  parameter int TARGET = 90
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd,
  input  logic signed [ERR_W-1:0] err,
  input  logic [SH_W-1:0]         kp_sh,
  input  logic [SH_W-1:0]         ki_sh,
  output logic signed [OUT_W-1:0] ctrl,
  output logic                    ctrl_vld
);
  localparam int IMIN = -(1 <<< (INT_W - 1));
  localparam int IMAX = (1 <<< (INT_W - 1)) - 1;
  localparam int OMIN = -(1 <<< (OUT_W - 1));
  localparam int OMAX = (1 <<< (OUT_W - 1)) - 1;

  logic signed [INT_W-1:0] integ_q;
  logic signed [INT_W-1:0] acc_q;
  int i_nxt, a_nxt, o_nxt;

  always_comb begin
    i_nxt = sat_int(int'(integ_q) + int'(err), IMIN, IMAX);
    a_nxt = sat_int(int'(acc_q) + i_nxt, IMIN, IMAX);
    o_nxt = sat_int((i_nxt >>> kp_sh) + (a_nxt >>> ki_sh), OMIN, OMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q  <= '0;
      acc_q    <= '0;
      ctrl     <= '0;
      ctrl_vld <= 1'b0;
    end else begin
      ctrl_vld <= upd;
      if (upd) begin
        integ_q <= INT_W'(i_nxt);
        acc_q   <= INT_W'(a_nxt);
        ctrl    <= OUT_W'(o_nxt);
      end
    end
  end

  // R4
  integ_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> ((int'(integ_q) - int'($past(integ_q))) <= TARGET &&
             (int'(integ_q) - int'($past(integ_q))) > TARGET - PH_MOD));

  // R4
  integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(integ_q) && $stable(acc_q));

endmodule

// File: rtl/ring_phase_loop.sv
`timescale 1ns/1ps
module ring_phase_loop #(
  parameter int CW     = 4,
  parameter int NPH    = 9,
  parameter int TARGET = 90,
  parameter int INT_W  = 16,
  parameter int OUT_W  = 12,
  parameter int SH_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CW-1:0]           coarse_cnt,
  input  logic [NPH-1:0]          ring_snap,
  input  logic [SH_W-1:0]         kp_shift,
  input  logic [SH_W-1:0]         ki_shift,
  output logic signed [OUT_W-1:0] ctrl_word,
  output logic                    ctrl_valid,
  output logic                    snap_err
);
  localparam int PH_MOD = (1 << CW) * NPH;
  localparam int PH_W   = $clog2(PH_MOD);
  localparam int IDX_W  = $clog2(NPH);
  localparam int ERR_W  = PH_W + 2;

  logic [IDX_W-1:0]        fine;
  logic                    bad;
  logic                    upd;
  logic signed [ERR_W-1:0] err;

  ring_snap_decode #(.NPH(NPH), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .snap(ring_snap), .fine_idx(fine), .bad(bad)
  );

  ring_phase_diff #(
    .CW(CW), .NPH(NPH), .IDX_W(IDX_W), .TARGET(TARGET),
    .PH_W(PH_W), .ERR_W(ERR_W)
  ) u_diff (
    .clk(clk), .rst(rst), .coarse(coarse_cnt), .fine(fine), .bad(bad),
    .upd(upd), .err(err)
  );

  ring_pi_filter #(
    .ERR_W(ERR_W), .INT_W(INT_W), .OUT_W(OUT_W), .SH_W(SH_W),
    .PH_MOD(PH_MOD), .TARGET(TARGET)
  ) u_pi (
    .clk(clk), .rst(rst), .upd(upd), .err(err),
    .kp_sh(kp_shift), .ki_sh(ki_shift),
    .ctrl(ctrl_word), .ctrl_vld(ctrl_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) snap_err <= 1'b0;
    else     snap_err <= bad;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ctrl_word == '0 && !ctrl_valid && !snap_err));

  // R7
  err_no_update_chk: assert property (@(posedge clk) disable iff (rst)
    snap_err |-> !ctrl_valid);

  // R7
  err_reacquire_chk: assert property (@(posedge clk) disable iff (rst)
    bad |=> !upd);

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_valid |-> $stable(ctrl_word));

endmodule

// File: tb/test_ring_phase_loop.sv
`timescale 1ns/1ps
module test_ring_phase_loop;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        coarse_cnt = '0;
  logic [8:0]        ring_snap = 9'b000001111;
  logic [3:0]        kp_shift = '0;
  logic [3:0]        ki_shift = '0;
  logic signed [11:0] ctrl_word;
  logic              ctrl_valid;
  logic              snap_err;

  ring_phase_loop i_ring_phase_loop (
    .clk(clk), .rst(rst), .coarse_cnt(coarse_cnt), .ring_snap(ring_snap),
    .kp_shift(kp_shift), .ki_shift(ki_shift),
    .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid), .snap_err(snap_err)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // reference model state
  bit m_ref_ok;
  int m_ref, m_int, m_acc, m_out;
  bit m_vld, m_err;
  int dph = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp(input int v, input int lim_lo, input int lim_hi);
    int r;
    r = v;
    if (r < lim_lo) r = lim_lo;
    if (r > lim_hi) r = lim_hi;
    return r;
  endfunction

  function automatic logic [8:0] mk_snap(input int fine, input int len);
    logic [8:0] s;
    s = '0;
    for (int k = 0; k < len; k++) s[(fine + k) % 9] = 1'b1;
    return s;
  endfunction

  task automatic model_reset();
    m_ref_ok = 0; m_ref = 0; m_int = 0; m_acc = 0; m_out = 0;
    m_vld = 0; m_err = 0;
  endtask

  task automatic model_step(input int c, input logic [8:0] s);
    int n, f, ph, adv, e;
    n = 0; f = 0;
    for (int k = 0; k < 9; k++)
      if (s[k] == 1'b1 && s[(k + 8) % 9] == 1'b0) begin n++; f = k; end
    if (n != 1) begin
      m_err = 1; m_vld = 0; m_ref_ok = 0;
    end else begin
      m_err = 0;
      ph = c * 9 + f;
      if (m_ref_ok) begin
        adv = ph - m_ref;
        while (adv < 0) adv += 144;
        e = 90 - adv;
        m_int = clamp(m_int + e, -32768, 32767);
        m_acc = clamp(m_acc + m_int, -32768, 32767);
        m_out = clamp((m_int >>> kp_shift) + (m_acc >>> ki_shift), -2048, 2047);
        m_vld = 1;
      end else begin
        m_vld = 0;
      end
      m_ref = ph; m_ref_ok = 1;
    end
  endtask

  task automatic compare_all();
    check(tag, int'(ctrl_valid), int'(m_vld), "ctrl_valid");
    check(tag, int'(snap_err), int'(m_err), "snap_err");
    check(tag, int'(ctrl_word), m_out, "ctrl_word");
  endtask

  task automatic step(input int c, input logic [8:0] s);
    coarse_cnt = 4'(c);
    ring_snap  = s;
    model_step(c, s);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n, input int inc, input int len);
    for (int k = 0; k < n; k++) begin
      dph = (dph + inc) % 144;
      step(dph / 9, mk_snap(dph % 9, len));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    model_reset();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    tag = "R1";
    compare_all();
    rst = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: first sample after reset only stores the reference
    tag = "R1";
    run(1, 90, 4);
    check("R1", int'(ctrl_valid), 0, "first sample ctrl_valid");

    // R2 R3: locked advance, with counter wrap and varied run lengths
    kp_shift = 4'd0; ki_shift = 4'd4;
    tag = "R3"; run(20, 90, 4);
    check("R3", int'(ctrl_word), 0, "locked ctrl_word");
    tag = "R2"; run(10, 90, 5); run(10, 90, 1); run(10, 90, 8);
    // R3: fast and slow oscillator
    tag = "R3"; run(15, 97, 4); run(15, 83, 5);
    // R6: gains change
    kp_shift = 4'd2; ki_shift = 4'd7;
    tag = "R6"; run(20, 91, 4); run(20, 88, 3);

    // R7: rejected snapshots
    tag = "R7";
    step(dph / 9, 9'b000000000);
    check("R7", int'(snap_err), 1, "all-zero snapshot flag");
    step(dph / 9, 9'b111111111);
    step(dph / 9, 9'b001100110);
    check("R7", int'(ctrl_valid), 0, "two-run snapshot ctrl_valid");
    // R8: held output while no update
    dph = (dph + 40) % 144;
    step(dph / 9, mk_snap(dph % 9, 4));
    check("R8", int'(ctrl_valid), 0, "reacquire no update");
    tag = "R7"; run(10, 92, 4);

    // R4 R5: positive saturation (advance 0, error 90)
    do_reset();
    kp_shift = 4'd8; ki_shift = 4'd9;
    tag = "R4"; run(400, 0, 4);
    check("R4", int'(ctrl_word), 127 + 63, "positive clamp output");
    // R5: negative saturation (advance 143, error -53)
    tag = "R5"; run(1400, 143, 5);
    check("R5", int'(ctrl_word), -128 - 64, "negative clamp output");
    // R6: output clamp
    kp_shift = 4'd0; ki_shift = 4'd0;
    tag = "R6"; run(3, 143, 4);
    check("R6", int'(ctrl_word), -2048, "output clamp");

    // R1: reset in the middle of a run
    do_reset();
    check("R1", int'(ctrl_word), 0, "mid-run reset ctrl_word");
    tag = "R1"; run(1, 70, 4);
    check("R1", int'(ctrl_valid), 0, "post-reset first sample");
    tag = "R3"; run(10, 89, 4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule